// File: doc/BRIEF.md
# Masked vector gather sequencer

This block performs one masked gather of eight 32-bit elements. A start strobe latches a base address, eight signed 32-bit indices, a two-bit scale code, an eight-bit lane mask and the previous destination vector. Each enabled lane computes its own address, base plus the sign-extended index shifted by the scale. The block then sends one load per lane, lowest lane first, to a memory port with a valid/ready request channel and an in-order response channel.

Returned data is merged into the destination lane, and that lane's mask bit is cleared. The mask therefore records progress. If a response carries an error, the block stops issuing and discards the responses still in flight. It reports the lane number. The mask bits of that lane and of every higher lane stay set, so a second start with the returned mask and destination resumes the operation where it stopped.

Top module: `gather_seq`

## Requirements
- R1: After reset, busy, done, fault and req_valid are low and mask_out is zero.
- R2: start is accepted only while busy is low. A start while busy changes neither the running operation nor its result.
- R3: A lane's address is base_addr + (sign-extended idx << scale_sel), truncated to ADDR_W bits. scale_sel 0, 1, 2 and 3 select a factor of 1, 2, 4 and 8. Lane n's index is idx_vec[32n+31:32n].
- R4: Requests are issued only for enabled lanes, in ascending lane order, at most one per cycle. A stalled request keeps its address until it is accepted.
- R5: A good response writes rsp_data into the matching dst_out lane (bits 32n+31:32n) and clears mask_out bit n. Lanes whose mask bit is clear keep their dst_in value.
- R6: done pulses for one cycle when every enabled lane has completed without error. With an all-zero mask, done is high in the cycle after start, and no request is made.
- R7: An error response sets fault and fault_lane to that lane, and no further request is issued. That lane and higher enabled lanes keep their mask bits and old data. Lower lanes stay completed. done does not pulse. fault holds until the next start.
- R8: No more than MAX_OUTS requests are outstanding at any time.
- R9: Restarting with the returned mask_out and dst_out completes only the remaining lanes and produces the same result as an uninterrupted gather.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a gather (accepted while idle) |
| base_addr | input | ADDR_W | Base address |
| idx_vec | input | 256 | Eight signed 32-bit indices |
| scale_sel | input | 2 | Scale code: 1, 2, 4 or 8 |
| mask_in | input | 8 | Lane enables |
| dst_in | input | 256 | Previous destination vector |
| req_valid | output | 1 | Load request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | ADDR_W | Load address |
| rsp_valid | input | 1 | Load response valid (in request order) |
| rsp_data | input | 32 | Load data |
| rsp_err | input | 1 | Load faulted |
| dst_out | output | 256 | Destination vector being merged |
| mask_out | output | 8 | Remaining lanes |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Gather stopped on a faulting lane |
| fault_lane | output | 3 | Lane that faulted |

## Verification
A new request for a higher lane and the retirement of a lower lane's response can fall in the same clock edge. Both update the in-flight lane set: one adds a bit, the other removes one. The responder model accepts requests and returns responses under pseudo-random ready and response timing, so this overlap occurs often across the sweep of all 256 masks at every scale. The bench judges it by checking every request address in lane order and by comparing the final vector and mask with values computed arithmetically. The same overlap with an error response is provoked in the fault runs. There the check is that no request follows the fault and that the discarded higher lanes keep their old data.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
    localparam int LANES  = 8;
    localparam int ELEM_W = 32;
    localparam int VEC_W  = LANES * ELEM_W;
    localparam int LANE_W = $clog2(LANES);

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANES-1:0]  lmask_t;

    typedef enum logic [1:0] {
        SC_X1 = 2'd0,
        SC_X2 = 2'd1,
        SC_X4 = 2'd2,
        SC_X8 = 2'd3
    } scale_e;

    typedef struct packed {
        logic  busy;
        logic  faulted;
        lane_t flane;
        logic  done;
    } ctl_t;
endpackage

// File: rtl/gsq_pick.sv
module gsq_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/gsq_addr_gen.sv
module gsq_addr_gen
    import gsq_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  idx_vec,
    input  lane_t             lane,
    input  scale_e            scale,
    output logic [ADDR_W-1:0] addr
);
    logic [ELEM_W-1:0]        ix;
    logic [ADDR_W+ELEM_W-1:0] wide;
    logic [ADDR_W-1:0]        scaled;

    always_comb begin
        ix     = idx_vec[int'(lane)*ELEM_W +: ELEM_W];
        wide   = {{ADDR_W{ix[ELEM_W-1]}}, ix};
        scaled = wide[ADDR_W-1:0] << scale;
        addr   = base + scaled;
    end
endmodule

// File: rtl/gsq_merge.sv
module gsq_merge
    import gsq_pkg::*;
(
    input  logic [VEC_W-1:0]  dst_q,
    input  lmask_t            mask_q,
    input  logic              ret,
    input  lane_t             ret_lane,
    input  logic [ELEM_W-1:0] data,
    input  logic              err,
    input  logic              faulted,
    output logic [VEC_W-1:0]  dst_n,
    output lmask_t            mask_n,
    output logic              fault_now
);
    always_comb begin
        dst_n     = dst_q;
        mask_n    = mask_q;
        fault_now = 1'b0;
        if (ret && !faulted) begin
            if (err) begin
                fault_now = 1'b1;
            end else begin
                dst_n[int'(ret_lane)*ELEM_W +: ELEM_W] = data;
                mask_n[ret_lane] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
    import gsq_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int MAX_OUTS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       base_addr,
    input  logic [VEC_W-1:0]        idx_vec,
    input  logic [1:0]              scale_sel,
    input  logic [LANES-1:0]        mask_in,
    input  logic [VEC_W-1:0]        dst_in,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [ADDR_W-1:0]       req_addr,
    input  logic                    rsp_valid,
    input  logic [ELEM_W-1:0]       rsp_data,
    input  logic                    rsp_err,
    output logic [VEC_W-1:0]        dst_out,
    output logic [LANES-1:0]        mask_out,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic [LANE_W-1:0]       fault_lane
);
    localparam int CW = $clog2(LANES + 1);

    ctl_t               ctl_q;
    logic [ADDR_W-1:0]  base_q;
    logic [VEC_W-1:0]   idx_q;
    scale_e             scale_q;
    logic [VEC_W-1:0]   dst_q;
    lmask_t             mask_q;
    lmask_t             todo_q;
    lmask_t             infl_q;

    logic               iss_any;
    lane_t              iss_lane;
    logic               ret_any;
    lane_t              ret_lane;
    logic [CW-1:0]      n_infl;
    logic               issue_ok;
    logic               fire;
    logic               ret;
    logic [VEC_W-1:0]   dst_n;
    lmask_t             mask_n;
    logic               fault_now;
    lmask_t             todo_n;
    lmask_t             infl_n;
    logic               fin;

    gsq_pick #(.N(LANES)) u_pick_iss (.vec(todo_q), .any(iss_any), .idx(iss_lane));
    gsq_pick #(.N(LANES)) u_pick_ret (.vec(infl_q), .any(ret_any), .idx(ret_lane));

    gsq_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base(base_q), .idx_vec(idx_q), .lane(iss_lane), .scale(scale_q), .addr(req_addr)
    );

    gsq_merge u_merge (
        .dst_q(dst_q), .mask_q(mask_q), .ret(ret), .ret_lane(ret_lane),
        .data(rsp_data), .err(rsp_err), .faulted(ctl_q.faulted),
        .dst_n(dst_n), .mask_n(mask_n), .fault_now(fault_now)
    );

    always_comb begin
        n_infl   = CW'($countones(infl_q));
        issue_ok = ctl_q.busy && !ctl_q.faulted && iss_any && (n_infl < CW'(MAX_OUTS));
        fire     = issue_ok && req_ready;
        ret      = ctl_q.busy && rsp_valid && ret_any;
        todo_n   = todo_q;
        infl_n   = infl_q;
        if (fire) begin
            todo_n[iss_lane] = 1'b0;
            infl_n[iss_lane] = 1'b1;
        end
        if (ret) infl_n[ret_lane] = 1'b0;
        if (fault_now) todo_n = '0;
        fin = ctl_q.busy && (todo_n == '0) && (infl_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            base_q  <= '0;
            idx_q   <= '0;
            scale_q <= SC_X1;
            dst_q   <= '0;
            mask_q  <= '0;
            todo_q  <= '0;
            infl_q  <= '0;
        end else begin
            ctl_q.done <= 1'b0;
            if (!ctl_q.busy && start) begin
                base_q        <= base_addr;
                idx_q         <= idx_vec;
                scale_q       <= scale_e'(scale_sel);
                dst_q         <= dst_in;
                mask_q        <= mask_in;
                todo_q        <= mask_in;
                infl_q        <= '0;
                ctl_q.faulted <= 1'b0;
                ctl_q.flane   <= '0;
                ctl_q.busy    <= |mask_in;
                ctl_q.done    <= ~|mask_in;
            end else if (ctl_q.busy) begin
                dst_q  <= dst_n;
                mask_q <= mask_n;
                todo_q <= todo_n;
                infl_q <= infl_n;
                if (fault_now) begin
                    ctl_q.faulted <= 1'b1;
                    ctl_q.flane   <= ret_lane;
                end
                if (fin) begin
                    ctl_q.busy <= 1'b0;
                    ctl_q.done <= !(ctl_q.faulted || fault_now);
                end
            end
        end
    end

    assign req_valid  = issue_ok;
    assign dst_out    = dst_q;
    assign mask_out   = mask_q;
    assign busy       = ctl_q.busy;
    assign done       = ctl_q.done;
    assign fault      = ctl_q.faulted;
    assign fault_lane = ctl_q.flane;

    // R2: operands stay put while a gather runs, even when start arrives
    a_r2_no_relaunch: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(base_q) && $stable(idx_q) && $stable(scale_q));

    // R4: a stalled request keeps its address
    a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready && !(rsp_valid && rsp_err) |=> req_valid && $stable(req_addr));

    // R5: mask bits only fall while a gather runs
    a_r5_mask_shrinks: assert property (@(posedge clk) disable iff (rst)
        busy |=> (mask_out & ~$past(mask_out)) == '0);

    // R6: completion only with an empty mask and no fault
    a_r6_done_clean: assert property (@(posedge clk) disable iff (rst)
        done |-> (mask_out == '0) && !fault && !busy);

    // R7: nothing is issued once a fault is recorded
    a_r7_quiet_after_fault: assert property (@(posedge clk) disable iff (rst)
        fault |-> !req_valid);

    // R8: outstanding loads bounded
    a_r8_outstanding_cap: assert property (@(posedge clk) disable iff (rst)
        $countones(infl_q) <= MAX_OUTS);
endmodule

// File: tb/sim_gather_seq.sv
module sim_gather_seq;
    localparam int PERIOD = 10;
    localparam int AW     = 40;
    localparam int MAXO   = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [AW-1:0]  base_addr = '0;
    logic [255:0]   idx_vec = '0;
    logic [1:0]     scale_sel = '0;
    logic [7:0]     mask_in = '0;
    logic [255:0]   dst_in = '0;
    logic           req_valid;
    logic           req_ready = 1'b0;
    logic [AW-1:0]  req_addr;
    logic           rsp_valid = 1'b0;
    logic [31:0]    rsp_data = '0;
    logic           rsp_err = 1'b0;
    logic [255:0]   dst_out;
    logic [7:0]     mask_out;
    logic           busy, done, fault;
    logic [2:0]     fault_lane;

    int errors = 0;
    int checks = 0;

    gather_seq #(.ADDR_W(AW), .MAX_OUTS(MAXO)) u0 (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .idx_vec(idx_vec),
        .scale_sel(scale_sel), .mask_in(mask_in), .dst_in(dst_in),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .dst_out(dst_out), .mask_out(mask_out), .busy(busy), .done(done),
        .fault(fault), .fault_lane(fault_lane)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] memf(logic [AW-1:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ 32'(a >> 8);
    endfunction

    function automatic logic [AW-1:0] lane_addr(logic [AW-1:0] b, logic [31:0] ix, logic [1:0] sc);
        logic [AW-1:0] ext;
        ext = {{(AW-32){ix[31]}}, ix};
        return b + (ext << sc);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder model state
    logic [AW-1:0] cur_base;
    logic [255:0]  cur_idx;
    logic [1:0]    cur_sc;
    logic [7:0]    exp_todo = '0;
    bit            fault_en = 0;
    logic [AW-1:0] fault_addr = '0;
    bit            spur_req = 0;
    bit            fast = 0;
    logic [AW-1:0] fifo [16];
    int            rd = 0, wr = 0, cnt = 0;
    logic [15:0]   lfsr = 16'hACE1;

    always @(negedge clk) begin
        if (rst) begin
            rsp_valid = 0; req_ready = 0; rd = 0; wr = 0; cnt = 0;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rsp_valid = (cnt > 0) && (fast || lfsr[0]);
            if (rsp_valid) begin
                rsp_data = memf(fifo[rd]);
                rsp_err  = fault_en && (fifo[rd] == fault_addr);
                rd = (rd + 1) % 16; cnt--;
            end else begin
                rsp_err = 0;
            end
            req_ready = fast || lfsr[1] || lfsr[2];
            if (req_valid && fault) spur_req = 1;
            if (req_valid && req_ready) begin
                int ln;
                ln = -1;
                for (int l = 7; l >= 0; l--) if (exp_todo[l]) ln = l;
                // R4: request must belong to the lowest remaining enabled lane
                if (ln < 0) begin
                    chk(0, "R4", "unexpected request", 256'(req_addr), 256'h0);
                end else begin
                    // R3: address arithmetic
                    chk(req_addr == lane_addr(cur_base, cur_idx[ln*32 +: 32], cur_sc),
                        "R3", "lane address", 256'(req_addr),
                        256'(lane_addr(cur_base, cur_idx[ln*32 +: 32], cur_sc)));
                    exp_todo[ln] = 1'b0;
                end
                fifo[wr] = req_addr; wr = (wr + 1) % 16; cnt++;
            end
        end
    end

    // one gather; flane < 0 means no fault injected
    task automatic run_gather(input logic [AW-1:0] b, input logic [255:0] ix, input logic [1:0] sc,
                              input logic [7:0] m, input logic [255:0] d, input int flane,
                              input bit poke, output logic [255:0] d_res, output logic [7:0] m_res);
        bit done_seen = 0;
        bit first_done = 0;
        int n = 0;
        logic [255:0] e_d;
        logic [7:0]   e_m;
        cur_base = b; cur_idx = ix; cur_sc = sc; exp_todo = m; spur_req = 0;
        fault_en = (flane >= 0);
        fault_addr = (flane >= 0) ? lane_addr(b, ix[flane*32 +: 32], sc) : '0;
        @(negedge clk);
        start = 1; base_addr = b; idx_vec = ix; scale_sel = sc; mask_in = m; dst_in = d;
        @(negedge clk);
        start = 0;
        first_done = done;
        if (done) done_seen = 1;
        while (busy && n < 400) begin
            @(negedge clk);
            n++;
            if (poke && n == 2 && busy) begin
                start = 1; base_addr = ~b; mask_in = 8'h00; dst_in = ~d; scale_sel = ~sc;
            end else begin
                start = 0;
            end
            if (done) done_seen = 1;
        end
        start = 0;
        @(negedge clk);
        if (done) done_seen = 1;
        chk(n < 400, "R6", "gather completes", 256'(n), 256'd400);
        e_d = d; e_m = m;
        for (int l = 0; l < 8; l++) begin
            if (m[l] && (flane < 0 || l < flane)) begin
                e_d[l*32 +: 32] = memf(lane_addr(b, ix[l*32 +: 32], sc));
                e_m[l] = 1'b0;
            end
        end
        chk(dst_out == e_d, poke ? "R2" : "R5", "dst_out", dst_out, e_d);
        chk(mask_out == e_m, (flane >= 0) ? "R7" : "R5", "mask_out", 256'(mask_out), 256'(e_m));
        if (flane >= 0) begin
            chk(fault && fault_lane == 3'(flane), "R7", "fault lane",
                256'({fault, fault_lane}), 256'({1'b1, 3'(flane)}));
            chk(!done_seen, "R7", "no done after fault", 256'(done_seen), 256'd0);
            chk(!spur_req, "R7", "request after fault", 256'(spur_req), 256'd0);
        end else begin
            chk(!fault, "R5", "fault clear", 256'(fault), 256'd0);
            chk(done_seen, "R6", "done pulse", 256'(done_seen), 256'd1);
            if (m == 8'h00)
                chk(first_done && n == 0, "R6", "zero mask done next cycle",
                    256'({first_done, 8'(n)}), 256'({1'b1, 8'd0}));
        end
        d_res = dst_out; m_res = mask_out;
    endtask

    function automatic logic [255:0] make_idx(int run);
        logic [255:0] v;
        for (int l = 0; l < 8; l++)
            v[l*32 +: 32] = 32'((l - 4) * 32'h0101_0037) + 32'(run * 13);
        return v;
    endfunction

    function automatic logic [255:0] make_dst(int run);
        logic [255:0] v;
        for (int l = 0; l < 8; l++)
            v[l*32 +: 32] = 32'hD000_0000 | 32'(run << 8) | 32'(l);
        return v;
    endfunction

    initial begin
        #(PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [255:0] dres, dres2;
        logic [7:0]   mres, mres2;
        logic [AW-1:0] b;
        int run;
        run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fault && !req_valid && mask_out == 8'h00, "R1", "reset state",
            256'({busy, done, fault, req_valid, mask_out}), 256'h0);

        // R3 R4 R5 R6 R8: every mask at every scale
        for (int sc = 0; sc < 4; sc++) begin
            for (int m = 0; m < 256; m++) begin
                fast = (m % 3 == 0);
                b = (run % 5 == 0) ? 40'hFF_FFFF_F000 : 40'h12_3456_0000 + AW'(run) * 40'h1000;
                run_gather(b, make_idx(run), 2'(sc), 8'(m), make_dst(run), -1, 0, dres, mres);
                run++;
            end
        end

        // R2: start while busy is ignored
        for (int k = 0; k < 4; k++) begin
            fast = 0;
            run_gather(40'h00_8000_0000, make_idx(run), 2'(k), 8'hFF, make_dst(run), -1, 1, dres, mres);
            run++;
        end

        // R7 R9: fault on each lane, then resume
        for (int fl = 0; fl < 8; fl++) begin
            logic [255:0] ix, d0, full;
            logic [7:0]   mm;
            fast = (fl % 2 == 0);
            ix = make_idx(run); d0 = make_dst(run);
            mm = (fl == 5) ? 8'b1011_0100 : 8'hFF;
            b = 40'h20_0000_0000 + AW'(fl) * 40'h100;
            run_gather(b, ix, 2'(fl % 4), mm, d0, fl == 5 ? 5 : fl, 0, dres, mres);
            run_gather(b, ix, 2'(fl % 4), mres, dres, -1, 0, dres2, mres2);
            full = d0;
            for (int l = 0; l < 8; l++)
                if (mm[l]) full[l*32 +: 32] = memf(lane_addr(b, ix[l*32 +: 32], 2'(fl % 4)));
            chk(dres2 == full && mres2 == 8'h00, "R9", "resume result", dres2, full);
            run++;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule